// File: doc/BRIEF.md
# Zero-Address Operand Stack with Add

This block is the operand store of a zero-address datapath. Operands are pushed onto a last-in, first-out stack and removed from it. Arithmetic instructions name no location: they work on whatever sits at the top. A small command port carries one command per clock. The command can be idle, push, pop or add, and a data input supplies the word to push. The block always shows the current top word. A popped word appears on its own output together with a one-cycle valid strobe.

The add command consumes the two topmost words and leaves their sum in their place, all in one clock. The occupancy count therefore falls by one. Illegal commands are refused and leave the stored words and the count untouched. A push onto a full stack is illegal, and so is a pop or an add with too few words. Each refused command raises one of two sticky error flags, which only reset clears.

Top module: `stack_alu_unit`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the cycle after it, the stack holds no words: `used` is 0, `empty` is 1, `full` is 0, `tos` is 0, `pop_valid` is 0, and both `overflow` and `underflow` are 0.
- R2: A command is taken only on a clock edge where `cmd_valid` is 1. The `cmd` encoding is 2'b00 idle, 2'b01 push, 2'b10 pop and 2'b11 add. An idle command, or any command with `cmd_valid` low, changes neither `used` nor `tos`.
- R3: An accepted push stores `push_data` as the new top word. After the edge, `tos` equals that word and `used` has risen by one.
- R4: Words leave in last-in, first-out order, and the first word pushed is the last one popped. An accepted pop puts the top word on `pop_data`, drives `pop_valid` high for exactly the following cycle, and lowers `used` by one.
- R5: An accepted add needs at least two words. It replaces the two top words with their sum modulo 2^WIDTH and lowers `used` by one. The words below them are unchanged.
- R6: `empty` is 1 exactly when `used` is 0, and `full` is 1 exactly when `used` equals DEPTH. `tos` reads 0 while the stack is empty.
- R7: A push when `used` equals DEPTH (16 by default) is refused. `used` and the stored words stay as they were, and `overflow` becomes 1 and stays 1 until reset.
- R8: A pop when the stack is empty, or an add with fewer than two words, is refused. `used` and the stored words stay as they were, no `pop_valid` pulse follows, and `underflow` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 2 | 00 idle, 01 push, 10 pop, 11 add |
| push_data | input | WIDTH | Word to push |
| pop_data | output | WIDTH | Last word removed by a pop |
| pop_valid | output | 1 | High for one cycle after an accepted pop |
| tos | output | WIDTH | Current top word, 0 when empty |
| used | output | $clog2(DEPTH+1) | Number of stored words; the top word lives at address used-1 |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Sticky: a push was refused |
| underflow | output | 1 | Sticky: a pop or add was refused |

## Verification
On every cycle the assertions check the local cause and effect of each command. They check the count step for each accepted push, pop and add, the new top after a push and after an add, and the pop strobe with its data. They also check the flag meanings and that both error flags are sticky. Only the bench scenarios can show properties that span many commands. These are the full last-in, first-out order of a filled stack, and that the lower words are intact after a refused push or a three-deep add. The wrap of the sum is also shown there.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_ADD  = 2'b11
  } stk_op_e;
endpackage

// File: rtl/stk_slots.sv
// Word storage: one register per slot, one write port, two read ports
// (the top slot and the slot just below it).
module stk_slots #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    top_addr,
  output logic [WIDTH-1:0] top_word,
  output logic [WIDTH-1:0] next_word
);
  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[i] <= '0;
      else if (wr_en && (wr_addr == AW'(i)))
        slot[i] <= wr_data;
    end
  end

  assign top_word  = slot[top_addr];
  assign next_word = slot[top_addr - AW'(1)];
endmodule

// File: rtl/stk_seq.sv
// Command decode, occupancy counter and sticky error flags.
module stk_seq
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  output logic [LW-1:0] level,
  output logic          ev_push,
  output logic          ev_pop,
  output logic          ev_add,
  output logic          overflow,
  output logic          underflow
);
  stk_op_e op;
  logic    ev_ovf, ev_unf;
  logic    has_one, has_two, at_cap;

  assign op      = stk_op_e'(cmd);
  assign has_one = (level != '0);
  assign has_two = (level > LW'(1));
  assign at_cap  = (level == LW'(DEPTH));

  always_comb begin
    ev_push = 1'b0;
    ev_pop  = 1'b0;
    ev_add  = 1'b0;
    ev_ovf  = 1'b0;
    ev_unf  = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_PUSH: begin ev_push = !at_cap;  ev_ovf = at_cap;   end
        OP_POP:  begin ev_pop  = has_one;  ev_unf = !has_one; end
        OP_ADD:  begin ev_add  = has_two;  ev_unf = !has_two; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (ev_push)
        level <= level + LW'(1);
      else if (ev_pop || ev_add)
        level <= level - LW'(1);
      if (ev_ovf) overflow  <= 1'b1;
      if (ev_unf) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/stack_alu_unit.sv
module stack_alu_unit #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_valid,
  output logic [WIDTH-1:0] tos,
  output logic [LW-1:0]    used,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  // Sum of two words, wrapping at the word width.
  function automatic logic [WIDTH-1:0] add_words(input logic [WIDTH-1:0] a,
                                                 input logic [WIDTH-1:0] b);
    return a + b;
  endfunction

  logic             ev_push, ev_pop, ev_add;
  logic             wr_en;
  logic [AW-1:0]    wr_addr, top_addr;
  logic [WIDTH-1:0] wr_data, top_word, next_word;

  stk_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
    .level(used), .ev_push(ev_push), .ev_pop(ev_pop), .ev_add(ev_add),
    .overflow(overflow), .underflow(underflow)
  );

  assign top_addr = AW'(used - LW'(1));
  assign wr_en    = ev_push || ev_add;
  assign wr_addr  = ev_push ? AW'(used) : AW'(used - LW'(2));
  assign wr_data  = ev_push ? push_data : add_words(top_word, next_word);

  stk_slots #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_slots (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .top_addr(top_addr),
    .top_word(top_word), .next_word(next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data  <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= ev_pop;
      if (ev_pop) pop_data <= top_word;
    end
  end

  assign empty = (used == '0);
  assign full  = (used == LW'(DEPTH));
  assign tos   = empty ? '0 : top_word;
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd,
  input logic [WIDTH-1:0] push_data,
  input logic [WIDTH-1:0] pop_data,
  input logic             pop_valid,
  input logic [WIDTH-1:0] tos,
  input logic [WIDTH-1:0] nos,
  input logic [LW-1:0]    used,
  input logic             empty,
  input logic             full,
  input logic             overflow,
  input logic             underflow
);
  logic do_push, do_pop, do_add, do_idle;
  assign do_push = cmd_valid && cmd == 2'b01;
  assign do_pop  = cmd_valid && cmd == 2'b10;
  assign do_add  = cmd_valid && cmd == 2'b11;
  assign do_idle = !cmd_valid || cmd == 2'b00;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (used == '0 && !pop_valid && !overflow && !underflow));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    do_idle |=> ($stable(used) && $stable(tos)));

  // R3
  push_top_chk: assert property (@(posedge clk) disable iff (rst)
    (do_push && !full) |=> (tos == $past(push_data) && used == $past(used) + LW'(1)));

  // R4
  pop_out_chk: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !empty) |=> (pop_valid && pop_data == $past(tos) && used == $past(used) - LW'(1)));

  // R4
  pop_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> $past(do_pop && !empty));

  // R5
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (do_add && used > LW'(1)) |=> (tos == WIDTH'($past(tos) + $past(nos)) && used == $past(used) - LW'(1)));

  // R6
  flag_meaning_chk: assert property (@(posedge clk) disable iff (rst)
    (empty == (used == '0)) && (full == (used == LW'(DEPTH))) && (!empty || tos == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (do_push && full) |=> (overflow && $stable(used) && $stable(tos)));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    ((do_pop && empty) || (do_add && used < LW'(2))) |=> (underflow && $stable(used) && $stable(tos) && !pop_valid));

  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
endmodule

bind stack_alu_unit stk_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
  .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
  .tos(tos), .nos(next_word), .used(used), .empty(empty), .full(full),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/sim_stack_alu_unit.sv
module sim_stack_alu_unit;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd = 2'b00;
  logic [WIDTH-1:0] push_data = '0;
  logic [WIDTH-1:0] pop_data, tos;
  logic             pop_valid, empty, full, overflow, underflow;
  logic [LW-1:0]    used;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stack_alu_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
    .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
    .tos(tos), .used(used), .empty(empty), .full(full),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_eq(input string what, input int act, input int exp);
    chk(act == exp, what, act, exp);
  endtask

  // Apply one command across one rising edge; outputs are read afterwards.
  task automatic issue(input bit v, input logic [1:0] c, input logic [WIDTH-1:0] d);
    cmd_valid = v;
    cmd = c;
    push_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd = 2'b00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R1 used", int'(used), 0);
    chk_eq("R1 empty", int'(empty), 1);
    chk_eq("R1 full", int'(full), 0);
    chk_eq("R1 tos", int'(tos), 0);
    chk_eq("R1 flags", int'({overflow, underflow, pop_valid}), 0);
  endtask

  task automatic t_lifo();
    logic [WIDTH-1:0] vals [3] = '{16'h1111, 16'hA5A5, 16'h0F0F};
    do_reset();
    foreach (vals[i]) begin
      issue(1'b1, 2'b01, vals[i]);
      chk_eq("R3 push tos", int'(tos), int'(vals[i]));
      chk_eq("R3 push used", int'(used), i + 1);
    end
    for (int i = 2; i >= 0; i--) begin
      issue(1'b1, 2'b10, '0);
      chk_eq("R4 pop data", int'(pop_data), int'(vals[i]));
      chk_eq("R4 pop valid", int'(pop_valid), 1);
      chk_eq("R4 pop used", int'(used), i);
    end
    @(negedge clk);
    chk_eq("R4 pop strobe one cycle", int'(pop_valid), 0);
    chk_eq("R6 empty after pops", int'(empty), 1);
    chk_eq("R6 tos zero when empty", int'(tos), 0);
  endtask

  task automatic t_idle();
    do_reset();
    issue(1'b1, 2'b01, 16'h00C3);
    issue(1'b0, 2'b01, 16'h7777);
    chk_eq("R2 invalid push used", int'(used), 1);
    chk_eq("R2 invalid push tos", int'(tos), 16'h00C3);
    issue(1'b0, 2'b11, '0);
    issue(1'b1, 2'b00, 16'h9999);
    chk_eq("R2 idle used", int'(used), 1);
    chk_eq("R2 idle tos", int'(tos), 16'h00C3);
  endtask

  task automatic t_add();
    do_reset();
    issue(1'b1, 2'b01, 16'd3);
    issue(1'b1, 2'b01, 16'd4);
    issue(1'b1, 2'b01, 16'd5);
    issue(1'b1, 2'b11, '0);
    chk_eq("R5 add tos", int'(tos), 9);
    chk_eq("R5 add used", int'(used), 2);
    issue(1'b1, 2'b10, '0);
    chk_eq("R5 add result popped", int'(pop_data), 9);
    issue(1'b1, 2'b10, '0);
    chk_eq("R5 lower word kept", int'(pop_data), 3);
    // wrap case
    issue(1'b1, 2'b01, 16'hFFFF);
    issue(1'b1, 2'b01, 16'h0002);
    issue(1'b1, 2'b11, '0);
    chk_eq("R5 wrap sum", int'(tos), 1);
    chk_eq("R5 wrap used", int'(used), 1);
    chk_eq("R5 no error", int'({overflow, underflow}), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++) issue(1'b1, 2'b01, WIDTH'(16'h0100 + i));
    chk_eq("R6 full", int'(full), 1);
    chk_eq("R6 used at cap", int'(used), DEPTH);
    chk_eq("R7 no overflow yet", int'(overflow), 0);
    issue(1'b1, 2'b01, 16'hDEAD);
    chk_eq("R7 overflow set", int'(overflow), 1);
    chk_eq("R7 used unchanged", int'(used), DEPTH);
    chk_eq("R7 tos unchanged", int'(tos), 16'h0100 + DEPTH - 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      issue(1'b1, 2'b10, '0);
      chk_eq("R4 full drain order", int'(pop_data), 16'h0100 + i);
    end
    chk_eq("R7 overflow sticky", int'(overflow), 1);
  endtask

  task automatic t_underflow();
    do_reset();
    issue(1'b1, 2'b10, '0);
    chk_eq("R8 pop empty flag", int'(underflow), 1);
    chk_eq("R8 pop empty no strobe", int'(pop_valid), 0);
    chk_eq("R8 pop empty used", int'(used), 0);
    do_reset();
    issue(1'b1, 2'b01, 16'h0055);
    issue(1'b1, 2'b11, '0);
    chk_eq("R8 add one word flag", int'(underflow), 1);
    chk_eq("R8 add one word used", int'(used), 1);
    chk_eq("R8 add one word tos", int'(tos), 16'h0055);
    issue(1'b1, 2'b01, 16'h0001);
    chk_eq("R8 underflow sticky", int'(underflow), 1);
    chk_eq("R8 overflow untouched", int'(overflow), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_lifo();
    t_idle();
    t_add();
    t_overflow();
    t_underflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule